// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block is the priority heart of one processor-local interrupt controller. It keeps three 256-bit vector arrays: pending requests, vectors in service, and a per-vector trigger-mode flag. Each array is built as eight 32-bit words. Requests arrive as a vector number with an edge or level tag. Software sets the task priority through a write strobe. The software-enable bit and the spurious vector come from a configuration write.

From the highest in-service vector and the task priority, the core works out the processor priority. It raises a registered interrupt line when the best pending request beats that priority by 16-vector class. On an acknowledge strobe it moves the chosen vector from pending to in-service and returns it one cycle later. When no request can be taken, the acknowledge returns the spurious vector instead and leaves the arrays untouched.

An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-tagged, the core announces a broadcast carrying the vector, unless broadcast suppression is enabled.

Top module: `vip_core`

## Requirements
- R1: After reset the interrupt line is low, the processor priority is 0x00, the configuration holds 0x0FF (disabled, spurious vector 0xFF), and an acknowledge returns vector 0xFF with the hit flag low.
- R2: The processor priority output equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that in-service upper nibble followed by a zero low nibble. With nothing in service, the in-service class counts as 0.
- R3: While configuration bit 8 (enable) is clear, or no request is pending, the interrupt line stays low. An acknowledge then returns the low byte of the configuration with the hit flag low, and no pending request is consumed.
- R4: A pending request is held when the processor priority is nonzero and the upper nibble of the highest pending vector is less than or equal to the upper nibble of the processor priority. Held requests keep the interrupt line low, and an acknowledge returns the spurious vector with the hit flag low. A processor priority of 0x00 never holds a request.
- R5: An acknowledge that finds a deliverable request selects the highest-numbered pending vector. It clears that vector's request bit, sets its in-service bit, and one cycle later presents the vector with the hit flag high.
- R6: A request with the level tag set marks the vector level-triggered. A request with the tag clear marks it edge-triggered, and the most recent request for a vector decides its mark.
- R7: An end-of-interrupt clears the highest in-service bit. If that vector is level-triggered and suppression is off, the broadcast valid output pulses one cycle later carrying the vector. With suppression on, or for an edge vector, or with nothing in service, no broadcast occurs.
- R8: A configuration write stores only data bits 8:0. Bits 7:0 form the spurious vector and bit 8 is the enable.
- R9: The interrupt line is a register. It reflects a change to the arrays, the task priority or the enable one clock after that change is stored.
- R10: When end-of-interrupt and acknowledge arrive in the same cycle, the end-of-interrupt is applied first. The acknowledge is judged against the processor priority left after that retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_data_i | input | 8 | Task priority value |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 16 | Configuration data; bits 8:0 kept |
| eoi_suppress_i | input | 1 | Suppress end-of-interrupt broadcasts |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Registered interrupt line |
| ppr_o | output | 8 | Current processor priority |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_vec_o | output | 8 | Returned vector (taken or spurious) |
| ack_hit_o | output | 1 | 1 = a real vector was taken |
| eoi_bcast_valid_o | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector of the broadcast |

## Verification
The bench targets several corner cases:
- Equal-class holds, where a request in the same class as the processor priority must be refused. A design comparing full bytes or using strict less-than would hand out the vector.
- A zero processor priority with a class-0 request. A design that dropped the nonzero condition would leave that request stuck.
- The same vector requested level and then edge. The later edge request must cancel the broadcast, and a sticky trigger bit would emit a spurious broadcast.
- An acknowledge and an end-of-interrupt in the same cycle. If the acknowledge were judged first, it would return the spurious vector.
- Priority picked across words and within a word, checking that the highest index is chosen.
- Acknowledges while the block is disabled, which must not consume the pending request.

// File: rtl/vip_pkg.sv
package vip_pkg;

  localparam int VIP_NVEC  = 256;
  localparam int VIP_WORD  = 32;
  localparam int VIP_VW    = $clog2(VIP_NVEC);
  localparam int VIP_CLS_W = 4;
  localparam int VIP_CFG_W = VIP_VW + 1;

  typedef logic [VIP_VW-1:0] vip_vec_t;

  // Priority class of a vector: its upper bits.
  function automatic logic [VIP_CLS_W-1:0] f_class(vip_vec_t v);
    return v[VIP_VW-1 -: VIP_CLS_W];
  endfunction

  // Processor priority from task priority and top in-service vector.
  function automatic vip_vec_t f_ppr(vip_vec_t tpr, logic isr_any, vip_vec_t isr_top);
    logic [VIP_CLS_W-1:0] svc_cls;
    svc_cls = isr_any ? f_class(isr_top) : '0;
    if (f_class(tpr) >= svc_cls) return tpr;
    return {svc_cls, {(VIP_VW-VIP_CLS_W){1'b0}}};
  endfunction

  // A request is held back when priority is nonzero and its class does not exceed it.
  function automatic logic f_held(vip_vec_t ppr, vip_vec_t irr_top);
    return (ppr != '0) && (f_class(irr_top) <= f_class(ppr));
  endfunction

endpackage

// File: rtl/vip_msb_enc.sv
module vip_msb_enc #(
  parameter int NVEC = vip_pkg::VIP_NVEC,
  parameter int WORD = vip_pkg::VIP_WORD
) (
  input  logic [NVEC-1:0]         vec_i,
  output logic                    any_o,
  output logic [$clog2(NVEC)-1:0] idx_o
);
  localparam int NWORD = NVEC / WORD;
  localparam int BW    = $clog2(WORD);
  localparam int VW    = $clog2(NVEC);

  logic [NWORD-1:0] w_any;
  logic [BW-1:0]    w_idx [NWORD];

  // First level: highest set bit inside each word.
  for (genvar g = 0; g < NWORD; g++) begin : g_word
    assign w_any[g] = |vec_i[g*WORD +: WORD];
    always_comb begin
      w_idx[g] = '0;
      for (int b = 0; b < WORD; b++) begin
        if (vec_i[g*WORD + b]) w_idx[g] = BW'(b);
      end
    end
  end

  // Second level: highest word holding any bit.
  always_comb begin
    any_o = |w_any;
    idx_o = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (w_any[w]) idx_o = VW'(w * WORD + int'(w_idx[w]));
    end
  end
endmodule

// File: rtl/vip_bit_array.sv
module vip_bit_array #(
  parameter int NVEC = vip_pkg::VIP_NVEC
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_en_i,
  input  logic [$clog2(NVEC)-1:0] clr_idx_i,
  input  logic                    set_en_i,
  input  logic [$clog2(NVEC)-1:0] set_idx_i,
  output logic [NVEC-1:0]         bits_o
);
  // Clear is applied first, so a set to the same index wins.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bits_o <= '0;
    end else begin
      if (clr_en_i) bits_o[clr_idx_i] <= 1'b0;
      if (set_en_i) bits_o[set_idx_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/vip_prio_eval.sv
module vip_prio_eval
  import vip_pkg::*;
(
  input  logic     en_i,
  input  vip_vec_t tpr_i,
  input  logic     isr_any_i,
  input  vip_vec_t isr_top_i,
  input  logic     irr_any_i,
  input  vip_vec_t irr_top_i,
  output vip_vec_t ppr_o,
  output logic     held_o,
  output logic     deliver_o
);
  always_comb begin
    ppr_o     = f_ppr(tpr_i, isr_any_i, isr_top_i);
    held_o    = irr_any_i && f_held(ppr_o, irr_top_i);
    deliver_o = en_i && irr_any_i && !held_o;
  end
endmodule

// File: rtl/vip_core.sv
module vip_core
  import vip_pkg::*;
#(
  parameter int NVEC = VIP_NVEC,
  parameter int WORD = VIP_WORD,
  parameter int CFGD = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [$clog2(NVEC)-1:0] req_vector_i,
  input  logic                    req_level_i,
  input  logic                    tpr_wr_i,
  input  logic [$clog2(NVEC)-1:0] tpr_data_i,
  input  logic                    cfg_wr_i,
  input  logic [CFGD-1:0]         cfg_data_i,
  input  logic                    eoi_suppress_i,
  input  logic                    ack_i,
  input  logic                    eoi_i,
  output logic                    irq_o,
  output logic [$clog2(NVEC)-1:0] ppr_o,
  output logic                    ack_valid_o,
  output logic [$clog2(NVEC)-1:0] ack_vec_o,
  output logic                    ack_hit_o,
  output logic                    eoi_bcast_valid_o,
  output logic [$clog2(NVEC)-1:0] eoi_bcast_vec_o
);
  localparam int VW    = $clog2(NVEC);
  localparam int CFG_W = VW + 1;

  logic [VW-1:0]    tpr_q;
  logic [CFG_W-1:0] spur_q;
  logic             enable;
  logic [VW-1:0]    spur_vec;

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] isr_post, eoi_mask;
  logic            irr_any, isr_any, post_any;
  logic [VW-1:0]   irr_top, isr_top, post_top;

  // Named internal events
  logic          eoi_fire;
  logic          ack_take;
  logic          ack_held;
  logic          ack_deliver;
  logic          now_deliver;
  logic          now_held;
  logic [VW-1:0] ppr_after_eoi;

  assign enable   = spur_q[CFG_W-1];
  assign spur_vec = spur_q[VW-1:0];

  vip_msb_enc #(.NVEC(NVEC), .WORD(WORD)) i_enc_irr (
    .vec_i(irr_q), .any_o(irr_any), .idx_o(irr_top));
  vip_msb_enc #(.NVEC(NVEC), .WORD(WORD)) i_enc_isr (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_top));

  // In-service view after this cycle's end-of-interrupt, used by the acknowledge.
  assign eoi_fire = eoi_i && isr_any;
  assign eoi_mask = eoi_fire ? (NVEC'(1) << isr_top) : '0;
  assign isr_post = isr_q & ~eoi_mask;

  vip_msb_enc #(.NVEC(NVEC), .WORD(WORD)) i_enc_post (
    .vec_i(isr_post), .any_o(post_any), .idx_o(post_top));

  // Status view: drives ppr_o and the interrupt line.
  vip_prio_eval i_eval_now (
    .en_i(enable), .tpr_i(tpr_q),
    .isr_any_i(isr_any), .isr_top_i(isr_top),
    .irr_any_i(irr_any), .irr_top_i(irr_top),
    .ppr_o(ppr_o), .held_o(now_held), .deliver_o(now_deliver));

  // Acknowledge view: judged after the end-of-interrupt of the same cycle.
  vip_prio_eval i_eval_ack (
    .en_i(enable), .tpr_i(tpr_q),
    .isr_any_i(post_any), .isr_top_i(post_top),
    .irr_any_i(irr_any), .irr_top_i(irr_top),
    .ppr_o(ppr_after_eoi), .held_o(ack_held), .deliver_o(ack_deliver));

  assign ack_take = ack_i && ack_deliver;

  vip_bit_array #(.NVEC(NVEC)) i_irr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_en_i(ack_take), .clr_idx_i(irr_top),
    .set_en_i(req_valid_i), .set_idx_i(req_vector_i),
    .bits_o(irr_q));

  vip_bit_array #(.NVEC(NVEC)) i_isr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_en_i(eoi_fire), .clr_idx_i(isr_top),
    .set_en_i(ack_take), .set_idx_i(irr_top),
    .bits_o(isr_q));

  vip_bit_array #(.NVEC(NVEC)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_en_i(req_valid_i && !req_level_i), .clr_idx_i(req_vector_i),
    .set_en_i(req_valid_i && req_level_i), .set_idx_i(req_vector_i),
    .bits_o(tmr_q));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tpr_q             <= '0;
      spur_q            <= {1'b0, {VW{1'b1}}};
      irq_o             <= 1'b0;
      ack_valid_o       <= 1'b0;
      ack_vec_o         <= '0;
      ack_hit_o         <= 1'b0;
      eoi_bcast_valid_o <= 1'b0;
      eoi_bcast_vec_o   <= '0;
    end else begin
      if (tpr_wr_i) tpr_q <= tpr_data_i;
      if (cfg_wr_i) spur_q <= cfg_data_i[CFG_W-1:0];
      irq_o             <= now_deliver;
      ack_valid_o       <= ack_i;
      ack_hit_o         <= ack_take;
      if (ack_i) ack_vec_o <= ack_take ? irr_top : spur_vec;
      eoi_bcast_valid_o <= eoi_fire && tmr_q[isr_top] && !eoi_suppress_i;
      if (eoi_fire) eoi_bcast_vec_o <= isr_top;
    end
  end

  // Assertions
  assert_disabled_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |=> !irq_o);

  assert_held_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_held) |=> (!ack_hit_o && ack_vec_o == $past(spur_vec)));

  assert_top_is_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irr_any |-> irr_q[irr_top]);

  assert_take_moves_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take && !(req_valid_i && req_vector_i == irr_top))
      |=> (isr_q[$past(irr_top)] && !irr_q[$past(irr_top)]));

  assert_bcast_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_valid_o |-> ($past(eoi_i) && !$past(eoi_suppress_i) && $past(tmr_q[isr_top])));

  assert_eoi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_fire && !(ack_take && irr_top == isr_top)) |=> !isr_q[$past(isr_top)]);

  assert_irq_rise_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(enable) && $past(irr_any)));

  assert_ack_after_eoi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take && eoi_fire) |=> ack_hit_o);
endmodule

// File: tb/test_vip_core.sv
module test_vip_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        tpr_wr = 1'b0;
  logic [7:0]  tpr_data = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        eoi_suppress = 1'b0;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;
  logic        irq;
  logic [7:0]  ppr;
  logic        ack_valid;
  logic [7:0]  ack_vec;
  logic        ack_hit;
  logic        bc_valid;
  logic [7:0]  bc_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int    ack_q[$];
  string ack_tag_q[$];
  int    bc_q[$];
  string bc_tag_q[$];

  always #2 clk = ~clk;

  vip_core i_vip_core (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vector_i(req_vector), .req_level_i(req_level),
    .tpr_wr_i(tpr_wr), .tpr_data_i(tpr_data),
    .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data),
    .eoi_suppress_i(eoi_suppress), .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq), .ppr_o(ppr),
    .ack_valid_o(ack_valid), .ack_vec_o(ack_vec), .ack_hit_o(ack_hit),
    .eoi_bcast_valid_o(bc_valid), .eoi_bcast_vec_o(bc_vec));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(int v, bit lvl);
    req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_tpr(int v);
    tpr_wr = 1'b1; tpr_data = 8'(v);
    @(negedge clk);
    tpr_wr = 1'b0;
  endtask

  task automatic do_cfg(int v);
    cfg_wr = 1'b1; cfg_data = 16'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Expected ack response encoded as {hit, vector}
  task automatic do_ack(bit hit, int v, string tag);
    ack_q.push_back({23'd0, hit, 8'(v)});
    ack_tag_q.push_back(tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_eoi(bit bc, int v, string tag);
    if (bc) begin
      bc_q.push_back(v);
      bc_tag_q.push_back(tag);
    end
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic do_both(int av, bit bc, int bv, string tag);
    ack_q.push_back({23'd0, 1'b1, 8'(av)});
    ack_tag_q.push_back(tag);
    if (bc) begin
      bc_q.push_back(bv);
      bc_tag_q.push_back(tag);
    end
    ack = 1'b1; eoi = 1'b1;
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
  endtask

  // Monitor: compares design results against the scoreboard queues.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ack_valid) begin
        if (ack_q.size() == 0) begin
          chk("R5 unexpected ack response", {ack_hit, ack_vec}, -1);
        end else begin
          chk(ack_tag_q.pop_front(), {23'd0, ack_hit, ack_vec}, ack_q.pop_front());
        end
      end
      if (rst_n && bc_valid) begin
        if (bc_q.size() == 0) begin
          chk("R7 unexpected broadcast", bc_vec, -1);
        end else begin
          chk(bc_tag_q.pop_front(), bc_vec, bc_q.pop_front());
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 irq after reset", irq, 0);
    chk("R1 ppr after reset", ppr, 8'h00);
    do_ack(0, 8'hFF, "R1 ack after reset");

    do_cfg(16'hF12F);
    do_ack(0, 8'h2F, "R8 spurious low byte, R3 empty");

    do_req(8'h45, 0);
    chk("R9 irq not yet", irq, 0);
    cyc(1);
    chk("R9 irq one cycle later", irq, 1);

    do_req(8'h80, 1);
    do_req(8'h30, 0);
    do_ack(1, 8'h80, "R5 highest taken");
    chk("R2 ppr from in-service", ppr, 8'h80);
    cyc(1);
    chk("R4 held irq low", irq, 0);
    do_ack(0, 8'h2F, "R4 held ack spurious");

    do_tpr(8'h95);
    chk("R2 ppr from tpr", ppr, 8'h95);
    do_tpr(8'h20);
    chk("R2 ppr class from isr", ppr, 8'h80);

    do_eoi(1, 8'h80, "R7 level broadcast");
    chk("R7 ppr after eoi", ppr, 8'h20);
    cyc(1);
    chk("R4 irq after eoi", irq, 1);

    do_ack(1, 8'h45, "R5 take 45");
    chk("R2 ppr 40", ppr, 8'h40);
    do_ack(0, 8'h2F, "R4 class 3 held by 4");
    do_eoi(0, 0, "R6 edge no broadcast");
    chk("R7 ppr back to tpr", ppr, 8'h20);
    do_ack(1, 8'h30, "R5 take 30");
    do_eoi(0, 0, "R6 edge 30");

    do_req(8'h60, 1);
    do_req(8'h60, 0);
    do_ack(1, 8'h60, "R6 take 60");
    do_eoi(0, 0, "R6 last edge clears level");
    do_req(8'h61, 1);
    do_ack(1, 8'h61, "R6 take 61");
    do_eoi(1, 8'h61, "R6 level broadcast 61");

    eoi_suppress = 1'b1;
    do_req(8'h70, 1);
    do_ack(1, 8'h70, "R7 take 70");
    do_eoi(0, 0, "R7 suppressed");
    eoi_suppress = 1'b0;

    do_req(8'h50, 1);
    do_ack(1, 8'h50, "R10 take 50");
    do_req(8'h40, 0);
    cyc(1);
    chk("R10 40 held by 50", irq, 0);
    do_both(8'h40, 1, 8'h50, "R10 eoi before ack");
    chk("R10 ppr after both", ppr, 8'h40);
    do_eoi(0, 0, "R10 retire 40");
    do_eoi(0, 0, "R7 eoi on empty");
    chk("R7 ppr unchanged on empty eoi", ppr, 8'h20);

    do_cfg(16'h002F);
    do_req(8'h90, 0);
    cyc(2);
    chk("R3 disabled irq low", irq, 0);
    do_ack(0, 8'h2F, "R3 disabled ack spurious");
    do_cfg(16'h012F);
    cyc(2);
    chk("R3 reenabled irq", irq, 1);
    do_ack(1, 8'h90, "R3 request kept while disabled");
    do_eoi(0, 0, "R3 retire 90");

    do_tpr(8'hA0);
    do_req(8'hA5, 0);
    cyc(2);
    chk("R4 equal class held", irq, 0);
    do_ack(0, 8'h2F, "R4 equal class ack spurious");
    do_tpr(8'h00);
    cyc(2);
    chk("R4 released", irq, 1);
    do_ack(1, 8'hA5, "R4 take A5");
    do_eoi(0, 0, "R4 retire A5");

    do_req(8'h05, 0);
    cyc(2);
    chk("R4 zero ppr never holds", irq, 1);
    do_ack(1, 8'h05, "R4 take class 0");
    do_eoi(0, 0, "R4 retire 05");

    do_req(8'h21, 0);
    do_req(8'h3F, 0);
    do_req(8'h25, 0);
    do_ack(1, 8'h3F, "R5 highest within word");
    do_ack(0, 8'h2F, "R4 class 2 held by 3");
    do_eoi(0, 0, "R5 retire 3F");
    do_ack(1, 8'h25, "R5 next 25");
    do_eoi(0, 0, "R5 retire 25");
    do_ack(1, 8'h21, "R5 next 21");
    do_eoi(0, 0, "R5 retire 21");
    do_req(8'hFF, 1);
    do_req(8'h01, 0);
    do_ack(1, 8'hFF, "R5 top vector across words");
    do_eoi(1, 8'hFF, "R7 broadcast FF");
    do_ack(1, 8'h01, "R5 low vector");
    do_eoi(0, 0, "R5 retire 01");

    cyc(4);
    chk("R5 ack queue drained", ack_q.size(), 0);
    chk("R7 broadcast queue drained", bc_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule